// File: doc/BRIEF.md
# Scalar-to-Vector Factor Generator

This block sits beside the scalar execution unit and turns each issued scalar opcode into the per-lane factors that the vector multiply-add consumes in its two-product form. Opcodes fall into a handful of classes. Each class decides where the factors come from and what scaling they carry: a lane mask taken from scalar source 1, the per-lane multiply products read with 8 or 16 fractional bits, an alternate per-lane operand, or plain zero. Many opcodes that have nothing to do with multiplication still produce factors as a side effect, and the block reproduces that.

Alongside the factors it reports a lane mask, whether the opcode writes the scalar register file, and whether it asks for the selected condition register to be cleared. An issued opcode is marked by `in_valid`. All outputs are registered and appear one cycle after the opcode. Between issues the factors and the mask hold their last value, and the single-cycle strobes return to zero.

Top module: `s2v_factor_gen`

## Requirements
- R1: After reset all factors, the lane mask, `out_valid`, `rf_wen` and `cond_clr` are zero.
- R2: Opcodes 0x40 to 0xFF form the mask class. `lane_mask` equals `src1_lo`, and for each lane i the factor is 0x100 when `src1_lo[i]` is 1 and 0 when it is 0. For every opcode outside this class `lane_mask` is 0.
- R3: A mask-class factor is never anything other than 0 or 0x100, and mask-class opcodes never assert `rf_wen` or `cond_clr`.
- R4: Below 0x40, any opcode that is not listed in R5, R6, R7, R9 or R10 gives all-zero factors, `rf_wen` = 0 and `cond_clr` = 0. Examples are 0x04, 0x0F, 0x08, 0x25 and 0x3E.
- R5: Opcodes 0x01, 0x11, 0x21 and 0x31 give, for each lane, product bits [17:8] plus product bit 7 when `round_req` is 1, with the sum truncated to 10 bits. They set `rf_wen` = 1.
- R6: Opcodes 0x00, 0x10, 0x20 and 0x30 give product bits [17:8] with no rounding, whatever `round_req` is. They set `rf_wen` = 0.
- R7: Opcodes 0x02, 0x12, 0x22 and 0x32 give product bits [9:0] and set `rf_wen` = 1. Opcodes 0x03, 0x13, 0x23 and 0x33 give the same factors with `rf_wen` = 0.
- R8: For the opcodes in R5 to R7, `op_neg` = 1 replaces each factor with its 10-bit two's complement negation.
- R9: Opcodes 0x06, 0x07 and 0x14 to 0x17 and 0x34 to 0x37 give product bits [9:0]. They ignore `op_neg` and `round_req`, and set `rf_wen` = 0.
- R10: Opcodes 0x1F, 0x2F and 0x3F set `cond_clr` = 1 and `rf_wen` = 0, and they ignore `op_neg`. 0x1F takes each lane's factor from `src2_alt`. 0x2F and 0x3F take product bits [9:0].
- R11: Each result appears one cycle after `in_valid`. `out_valid` follows `in_valid` with that one-cycle delay. While `in_valid` is 0, the factors and `lane_mask` hold their values, and `rf_wen` and `cond_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An opcode is issued this cycle |
| opcode | input | 8 | Scalar opcode |
| op_neg | input | 1 | Negate flag carried in the opcode's flag bits |
| round_req | input | 1 | Rounding flag |
| src1_lo | input | LANES (4) | Low bits of scalar source 1 |
| src2_alt | input | LANES*FACT_W (40) | Per-lane mangled source 2 values |
| products | input | LANES*PROD_W (72) | Per-lane multiply products, lane 0 in the low bits |
| out_valid | output | 1 | Factors belong to an opcode issued the previous cycle |
| factors | output | LANES*FACT_W (40) | Per-lane factors, lane 0 in the low bits |
| lane_mask | output | LANES (4) | Factor mask |
| rf_wen | output | 1 | Opcode writes the scalar register |
| cond_clr | output | 1 | Clear the selected condition register |

## Verification
Every result is due one clock edge after the opcode is presented. The bench drives the inputs on a falling edge, removes `in_valid` on the next falling edge, and reads every output at that same moment, which comes after exactly one rising edge. The hold behaviour is checked one more idle cycle later, to confirm that the factors are unchanged and the strobes have dropped.

// File: rtl/s2vf_pkg.sv
package s2vf_pkg;

   typedef enum logic [1:0] {
      K_ZERO = 2'd0,
      K_MASK = 2'd1,
      K_F8   = 2'd2,
      K_F16  = 2'd3
   } kind_e;

   typedef struct packed {
      kind_e kind;
      logic  rnd_ok;
      logic  neg_ok;
      logic  use_alt;
      logic  rwe;
      logic  clr;
   } dec_t;

endpackage

// File: rtl/s2vf_decode.sv
module s2vf_decode
   import s2vf_pkg::*;
(
   input  logic [7:0] op,
   output dec_t       d
);

   always_comb begin
      d        = '0;
      d.kind   = K_ZERO;
      if (op[7:6] != 2'b00) begin
         d.kind = K_MASK;
      end else if (op[3:2] == 2'b00) begin
         d.kind   = op[1] ? K_F16 : K_F8;
         d.rnd_ok = (op[1:0] == 2'b01);
         d.neg_ok = 1'b1;
         d.rwe    = (op[1:0] == 2'b01) || (op[1:0] == 2'b10);
      end else if (op inside {8'h06, 8'h07, [8'h14:8'h17], [8'h34:8'h37]}) begin
         d.kind = K_F16;
      end else if (op inside {8'h1f, 8'h2f, 8'h3f}) begin
         d.kind    = K_F16;
         d.clr     = 1'b1;
         d.use_alt = (op == 8'h1f);
      end
   end

endmodule

// File: rtl/s2vf_lane.sv
module s2vf_lane
   import s2vf_pkg::*;
#(
   parameter int FACT_W = 10,
   parameter int PROD_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dec_t              d,
   input  logic              rnd,
   input  logic              neg,
   input  logic              mbit,
   input  logic [PROD_W-1:0] prod,
   input  logic [FACT_W-1:0] alt,
   output logic [FACT_W-1:0] fac
);

   localparam logic [FACT_W-1:0] ONE = FACT_W'(1) << (FACT_W - 2);

   logic [FACT_W-1:0] base;
   logic              rbit;

   assign rbit = d.rnd_ok & rnd & prod[7];

   always_comb begin
      unique case (d.kind)
         K_MASK:  base = mbit ? ONE : '0;
         K_F8:    base = prod[FACT_W+7:8] + FACT_W'(rbit);
         K_F16:   base = d.use_alt ? alt : prod[FACT_W-1:0];
         default: base = '0;
      endcase
      fac = (d.neg_ok & neg) ? (~base + FACT_W'(1)) : base;
   end

   // R3: mask-derived factor is only ever zero or one
   p_mask_val_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (d.kind == K_MASK) |-> (fac == '0 || fac == ONE));

endmodule

// File: rtl/s2v_factor_gen.sv
module s2v_factor_gen
   import s2vf_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int FACT_W = 10,
   parameter int PROD_W = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [7:0]              opcode,
   input  logic                    op_neg,
   input  logic                    round_req,
   input  logic [LANES-1:0]        src1_lo,
   input  logic [LANES*FACT_W-1:0] src2_alt,
   input  logic [LANES*PROD_W-1:0] products,
   output logic                    out_valid,
   output logic [LANES*FACT_W-1:0] factors,
   output logic [LANES-1:0]        lane_mask,
   output logic                    rf_wen,
   output logic                    cond_clr
);

   localparam int FBUS = LANES * FACT_W;

   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("LANES out of range");
   end
   if (FACT_W < 9) begin : g_bad_fact
      $error("FACT_W must hold the unit value");
   end
   if (PROD_W != FACT_W + 8) begin : g_bad_prod
      $error("PROD_W must be FACT_W + 8");
   end

   dec_t            dec;
   logic [FBUS-1:0] fac_d;
   logic [FBUS-1:0] fac_q;
   logic [LANES-1:0] mask_q;
   logic            vld_q, rwe_q, clr_q;

   s2vf_decode u_dec (
      .op (opcode),
      .d  (dec)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      s2vf_lane #(
         .FACT_W (FACT_W),
         .PROD_W (PROD_W)
      ) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (dec),
         .rnd   (round_req),
         .neg   (op_neg),
         .mbit  (src1_lo[i]),
         .prod  (products[i*PROD_W +: PROD_W]),
         .alt   (src2_alt[i*FACT_W +: FACT_W]),
         .fac   (fac_d[i*FACT_W +: FACT_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fac_q  <= '0;
         mask_q <= '0;
         vld_q  <= 1'b0;
         rwe_q  <= 1'b0;
         clr_q  <= 1'b0;
      end else begin
         vld_q <= in_valid;
         rwe_q <= in_valid & dec.rwe;
         clr_q <= in_valid & dec.clr;
         if (in_valid) begin
            fac_q  <= fac_d;
            mask_q <= (dec.kind == K_MASK) ? src1_lo : '0;
         end
      end
   end

   assign out_valid = vld_q;
   assign factors   = fac_q;
   assign lane_mask = mask_q;
   assign rf_wen    = rwe_q;
   assign cond_clr  = clr_q;

   // R11: one-cycle latency of the valid strobe
   p_lat_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_lat_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R11: idle cycles keep the factors steady
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(factors));
   // R10: a condition clear only accompanies a valid result
   p_clr_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cond_clr |-> out_valid);
   // R3: mask class never writes the scalar register or clears a condition
   p_mask_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode[7:6] != 2'b00) |=> (!rf_wen && !cond_clr));
   // R7: write enable and condition clear never coincide
   p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_wen && cond_clr));

endmodule

// File: tb/s2v_factor_gen_bench.sv
module s2v_factor_gen_bench;

   localparam int L = 4;
   localparam int FW = 10;
   localparam int PW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    opcode = '0;
   logic          op_neg = 1'b0;
   logic          round_req = 1'b0;
   logic [L-1:0]  src1_lo = '0;
   logic [L*FW-1:0] src2_alt = '0;
   logic [L*PW-1:0] products = '0;
   logic          out_valid;
   logic [L*FW-1:0] factors;
   logic [L-1:0]  lane_mask;
   logic          rf_wen;
   logic          cond_clr;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   s2v_factor_gen u_s2v_factor_gen (
      .clk, .rst_n, .in_valid, .opcode, .op_neg, .round_req, .src1_lo,
      .src2_alt, .products, .out_valid, .factors, .lane_mask, .rf_wen, .cond_clr
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] m_lane(input logic [7:0] op, input logic rnd,
         input logic neg, input logic mb, input logic [PW-1:0] p, input logic [FW-1:0] a);
      logic [FW-1:0] v;
      if (op >= 8'h40) return mb ? 10'h100 : 10'h000;
      if (op[3:0] <= 4'd3) begin
         if (op[3:0] < 4'd2) v = p[17:8] + ((op[3:0] == 4'd1 && rnd && p[7]) ? 10'd1 : 10'd0);
         else v = p[9:0];
         if (neg) v = -v;
         return v;
      end
      if (op inside {8'h06, 8'h07, [8'h14:8'h17], [8'h34:8'h37]}) return p[9:0];
      if (op == 8'h1f) return a;
      if (op inside {8'h2f, 8'h3f}) return p[9:0];
      return '0;
   endfunction

   task automatic run(input string req, input logic [7:0] op, input logic rnd, input logic neg,
         input logic [L-1:0] s1, input logic [L*PW-1:0] pr, input logic [L*FW-1:0] al);
      logic [L*FW-1:0] ef;
      logic ew, ec;
      @(negedge clk);
      in_valid = 1'b1; opcode = op; round_req = rnd; op_neg = neg;
      src1_lo = s1; products = pr; src2_alt = al;
      for (int i = 0; i < L; i++)
         ef[i*FW +: FW] = m_lane(op, rnd, neg, s1[i], pr[i*PW +: PW], al[i*FW +: FW]);
      ew = (op < 8'h40) && (op[3:0] == 4'd1 || op[3:0] == 4'd2);
      ec = (op == 8'h1f) || (op == 8'h2f) || (op == 8'h3f);
      @(negedge clk);
      in_valid = 1'b0;
      chk(req, "factors", factors, ef);
      chk(req, "lane_mask", lane_mask, (op >= 8'h40) ? s1 : '0);
      chk(req, "rf_wen", rf_wen, ew);
      chk(req, "cond_clr", cond_clr, ec);
      chk("R11", "out_valid", out_valid, 1);
   endtask

   localparam logic [L*PW-1:0] PA = {18'h3_FF7F, 18'h0_0100, 18'h1_2380, 18'h2_3480};
   localparam logic [L*PW-1:0] PB = {18'h0_03FF, 18'h2_A955, 18'h0_0080, 18'h1_5A5A};
   localparam logic [L*FW-1:0] AA = {10'h3A5, 10'h011, 10'h2C0, 10'h07F};

   task automatic t_reset;
      chk("R1", "factors", factors, 0);
      chk("R1", "lane_mask", lane_mask, 0);
      chk("R1", "out_valid", out_valid, 0);
      chk("R1", "rf_wen", rf_wen, 0);
      chk("R1", "cond_clr", cond_clr, 0);
   endtask

   task automatic t_mask;
      run("R2", 8'h45, 1'b0, 1'b0, 4'b1010, PA, AA);
      run("R2", 8'h40, 1'b1, 1'b1, 4'b0111, PB, AA);
      run("R3", 8'hFF, 1'b1, 1'b1, 4'b1111, PA, AA);
      run("R3", 8'h80, 1'b0, 1'b0, 4'b0000, PA, AA);
   endtask

   task automatic t_zero;
      run("R4", 8'h04, 1'b1, 1'b1, 4'b1111, PA, AA);
      run("R4", 8'h0F, 1'b1, 1'b0, 4'b1111, PB, AA);
      run("R4", 8'h08, 1'b0, 1'b0, 4'b0101, PA, AA);
      run("R4", 8'h25, 1'b0, 1'b1, 4'b0101, PB, AA);
      run("R4", 8'h3E, 1'b1, 1'b0, 4'b0101, PA, AA);
   endtask

   task automatic t_frac8;
      run("R5", 8'h01, 1'b1, 1'b0, 4'b0000, PA, AA);
      run("R5", 8'h21, 1'b0, 1'b0, 4'b0000, PA, AA);
      run("R5", 8'h31, 1'b1, 1'b0, 4'b0000, PB, AA);
      run("R6", 8'h00, 1'b1, 1'b0, 4'b0000, PA, AA);
      run("R6", 8'h30, 1'b1, 1'b0, 4'b0000, PB, AA);
   endtask

   task automatic t_frac16;
      run("R7", 8'h02, 1'b1, 1'b0, 4'b0000, PA, AA);
      run("R7", 8'h13, 1'b0, 1'b0, 4'b0000, PB, AA);
      run("R7", 8'h33, 1'b1, 1'b0, 4'b0000, PA, AA);
   endtask

   task automatic t_neg;
      run("R8", 8'h11, 1'b1, 1'b1, 4'b0000, PA, AA);
      run("R8", 8'h22, 1'b0, 1'b1, 4'b0000, PB, AA);
      run("R8", 8'h10, 1'b1, 1'b1, 4'b0000, PB, AA);
   endtask

   task automatic t_flagless;
      run("R9", 8'h06, 1'b1, 1'b1, 4'b1111, PA, AA);
      run("R9", 8'h17, 1'b1, 1'b1, 4'b1111, PB, AA);
      run("R9", 8'h35, 1'b0, 1'b1, 4'b1111, PA, AA);
   endtask

   task automatic t_clear;
      run("R10", 8'h1F, 1'b1, 1'b1, 4'b1111, PA, AA);
      run("R10", 8'h2F, 1'b0, 1'b1, 4'b1111, PB, AA);
      run("R10", 8'h3F, 1'b1, 1'b0, 4'b1111, PA, AA);
   endtask

   task automatic t_hold;
      logic [L*FW-1:0] keep;
      run("R11", 8'h02, 1'b0, 1'b0, 4'b0000, PB, AA);
      run("R11", 8'h46, 1'b0, 1'b0, 4'b1001, PB, AA);
      keep = factors;
      opcode = 8'h1F; products = PA; src1_lo = 4'b0110;
      @(negedge clk);
      chk("R11", "held factors", factors, keep);
      chk("R11", "held lane_mask", lane_mask, 4'b1001);
      chk("R11", "idle out_valid", out_valid, 0);
      chk("R11", "idle rf_wen", rf_wen, 0);
      chk("R11", "idle cond_clr", cond_clr, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_zero();
      t_frac8();
      t_frac16();
      t_neg();
      t_flagless();
      t_clear();
      t_hold();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule